// File: doc/BRIEF.md
# Serial Flash Status Byte and Busy Timer

This block produces the status byte of a serial flash device and models the self-timed busy interval that follows every internal array operation. The command front-end sends a one-cycle launch pulse tagged with a three-bit operation class. The block loads a cycle counter with the matching duration and holds the ready bit low while that counter runs. Transfers and compares use a short duration. All erase and program operations use a longer one.

While the front-end marks a status-read command as active, the block presents the status byte serially, most significant bit first. It advances one bit on each shift strobe and starts over after the last bit. Bit 7 comes straight from the live ready flag. A host that stops shifting while bit 7 is on the line therefore sees the output rise from 0 to 1 when the operation finishes. The other bits are constant: a fixed density lookup code and zero fillers. The density code is a code for one of sixteen density configurations, not a binary size.

Top module: `flash_status_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ready` is 1 and `so` is 0 with `readActive` low.
- R2: The status byte is {ready, 0, DENSITY_CODE[3:0], 0, 0}. With the default code 4'b0111 it reads 0x9C when ready and 0x1C when busy.
- R3: While `readActive` is high, `so` shows bit 7 before any shift. Each cycle with `shiftStb` high moves the output one bit lower, and after bit 0 the next bit is bit 7 again.
- R4: A launch accepted while ready drops `ready` on the next edge and keeps it low for exactly XFER_CYCLES cycles for class codes 0 (page to buffer transfer) and 1 (page to buffer compare). It keeps it low for exactly PROG_CYCLES cycles for class codes 2 to 7: buffer program with erase, buffer program without erase, page erase, block erase, page program through buffer, auto page rewrite.
- R5: A launch pulse that arrives while `ready` is low has no effect: the busy interval neither restarts nor changes length.
- R6: With `readActive` held high and no shift strobes, `so` follows the live ready bit and rises from 0 to 1 in the cycle that `ready` rises.
- R7: While `readActive` is low, `so` is 0 and `shiftStb` is ignored. The next read always begins at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | One-cycle pulse starting an internal operation |
| launchClass | input | 3 | Operation class code, valid with launchValid |
| readActive | input | 1 | High while a status-read command is in progress |
| shiftStb | input | 1 | One-cycle strobe advancing the serial output by one bit |
| so | output | 1 | Serial status output |
| ready | output | 1 | 1 when no internal operation is running |

## Verification
The assertions assume that `launchValid` and `shiftStb` are synchronous to `clk`, that `launchClass` is stable whenever `launchValid` is high, and that `readActive` is a level that is held for the whole read. Their shift tracking also relies on no strobe being counted while `readActive` is low. The bench drives every input on the falling clock edge only, so each pulse lasts exactly one rising edge. It raises `shiftStb` only inside a read, except for one deliberate stray burst with `readActive` low, which is sent to check that such strobes are ignored.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    OP_PAGE_TO_BUF       = 3'd0,
    OP_PAGE_CMP          = 3'd1,
    OP_BUF_PGM_ERASE     = 3'd2,
    OP_BUF_PGM_NOERASE   = 3'd3,
    OP_PAGE_ERASE        = 3'd4,
    OP_BLOCK_ERASE       = 3'd5,
    OP_PAGE_PGM_THRU_BUF = 3'd6,
    OP_AUTO_REWRITE      = 3'd7
  } opClass_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } busyState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadProg;
    logic loadXfer;
    logic countDown;
    logic ptrRewind;
    logic ptrStep;
  } statStrobe_t;

  function automatic logic isShortClass(opClass_e c);
    return (c == OP_PAGE_TO_BUF) || (c == OP_PAGE_CMP);
  endfunction

endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launchValid,
  input  logic [2:0]  launchClass,
  input  logic        readActive,
  input  logic        shiftStb,
  input  logic        cntLast,
  output statStrobe_t strobes,
  output logic        ready
);

  busyState_e stateQ, stateD;
  opClass_e   opClass;

  assign opClass = opClass_e'(launchClass);

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD            = stateQ;
    strobes           = '0;
    strobes.ptrRewind = !readActive;
    strobes.ptrStep   = readActive && shiftStb;
    unique case (stateQ)
      ST_IDLE: begin
        if (launchValid) begin
          if (isShortClass(opClass)) strobes.loadXfer = 1'b1;
          else                       strobes.loadProg = 1'b1;
          stateD = ST_BUSY;
        end
      end
      ST_BUSY: begin
        strobes.countDown = 1'b1;
        if (cntLast) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign ready = (stateQ == ST_IDLE);

endmodule

// File: rtl/flash_stat_dp.sv
module flash_stat_dp
  import flash_stat_pkg::*;
#(
  parameter int         PROG_CYCLES  = 2000,
  parameter int         XFER_CYCLES  = 200,
  parameter logic [3:0] DENSITY_CODE = 4'b0111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  statStrobe_t strobes,
  input  logic        ready,
  input  logic        readActive,
  output logic        cntLast,
  output logic        so
);

  localparam int MAX_CYCLES = (PROG_CYCLES > XFER_CYCLES) ? PROG_CYCLES : XFER_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam int BYTE_W     = 8;
  localparam int PTR_W      = $clog2(BYTE_W);

  logic [CNT_W-1:0]  remain;
  logic [PTR_W-1:0]  bitPtr;
  logic [BYTE_W-1:0] statusByte;

  // Busy interval counter
  always_ff @(posedge clk) begin
    if (!rst_n)                 remain <= '0;
    else if (strobes.loadProg)  remain <= CNT_W'(PROG_CYCLES);
    else if (strobes.loadXfer)  remain <= CNT_W'(XFER_CYCLES);
    else if (strobes.countDown) remain <= remain - CNT_W'(1);
  end

  assign cntLast = (remain == CNT_W'(1));

  // Serial bit pointer, counts down and wraps from 0 to the top bit
  always_ff @(posedge clk) begin
    if (!rst_n)                 bitPtr <= PTR_W'(BYTE_W - 1);
    else if (strobes.ptrRewind) bitPtr <= PTR_W'(BYTE_W - 1);
    else if (strobes.ptrStep)   bitPtr <= bitPtr - PTR_W'(1);
  end

  assign statusByte = {ready, 1'b0, DENSITY_CODE, 2'b00};
  assign so         = readActive & statusByte[bitPtr];

endmodule

// File: rtl/flash_status_timer.sv
module flash_status_timer
  import flash_stat_pkg::*;
#(
  parameter int         PROG_CYCLES  = 2000,
  parameter int         XFER_CYCLES  = 200,
  parameter logic [3:0] DENSITY_CODE = 4'b0111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launchValid,
  input  logic [2:0] launchClass,
  input  logic       readActive,
  input  logic       shiftStb,
  output logic       so,
  output logic       ready
);

  statStrobe_t strobes;
  logic        cntLast;

  flash_stat_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .launchValid (launchValid),
    .launchClass (launchClass),
    .readActive  (readActive),
    .shiftStb    (shiftStb),
    .cntLast     (cntLast),
    .strobes     (strobes),
    .ready       (ready)
  );

  flash_stat_dp #(
    .PROG_CYCLES  (PROG_CYCLES),
    .XFER_CYCLES  (XFER_CYCLES),
    .DENSITY_CODE (DENSITY_CODE)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .ready      (ready),
    .readActive (readActive),
    .cntLast    (cntLast),
    .so         (so)
  );

endmodule

// File: rtl/flash_status_timer_chk.sv
module flash_status_timer_chk #(
  parameter int         PROG_CYCLES  = 2000,
  parameter int         XFER_CYCLES  = 200,
  parameter logic [3:0] DENSITY_CODE = 4'b0111
) (
  input logic       clk,
  input logic       rst_n,
  input logic       launchValid,
  input logic [2:0] launchClass,
  input logic       readActive,
  input logic       shiftStb,
  input logic       so,
  input logic       ready
);

  localparam int MAX_CYCLES = (PROG_CYCLES > XFER_CYCLES) ? PROG_CYCLES : XFER_CYCLES;

  int         lowRun;
  int         expLen;
  logic [2:0] shiftsSeen;

  always_ff @(posedge clk) begin
    if (!rst_n)     lowRun <= 0;
    else if (!ready) lowRun <= lowRun + 1;
    else             lowRun <= 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) expLen <= 0;
    else if (ready && launchValid)
      expLen <= (launchClass < 3'd2) ? XFER_CYCLES : PROG_CYCLES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !readActive) shiftsSeen <= '0;
    else if (shiftStb)         shiftsSeen <= shiftsSeen + 3'd1;
  end

  // R4: accepted launch drops ready on the next edge
  a_r4_launch_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && launchValid) |=> !ready);

  // R4 / R5: busy run length equals the class duration of the accepted launch
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && lowRun != 0) |-> (lowRun == expLen));

  // R5: no busy interval outlasts the longest duration
  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lowRun <= MAX_CYCLES);

  // R7: output quiet outside a read
  a_r7_idle_so_low: assert property (@(posedge clk) disable iff (!rst_n)
    !readActive |-> !so);

  // R6: top bit on the line follows the live ready flag
  a_r6_poll_live: assert property (@(posedge clk) disable iff (!rst_n)
    (readActive && shiftsSeen == 3'd0) |-> (so == ready));

  // R2: bit 6 reads zero
  a_r2_bit6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (readActive && shiftsSeen == 3'd1) |-> !so);

  // R2: most significant density bit at bit 5
  a_r2_density_top: assert property (@(posedge clk) disable iff (!rst_n)
    (readActive && shiftsSeen == 3'd2) |-> (so == DENSITY_CODE[3]));

  // R2: bit 0 reads zero
  a_r2_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (readActive && shiftsSeen == 3'd7) |-> !so);

endmodule

bind flash_status_timer flash_status_timer_chk #(
  .PROG_CYCLES  (PROG_CYCLES),
  .XFER_CYCLES  (XFER_CYCLES),
  .DENSITY_CODE (DENSITY_CODE)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .launchValid (launchValid),
  .launchClass (launchClass),
  .readActive  (readActive),
  .shiftStb    (shiftStb),
  .so          (so),
  .ready       (ready)
);

// File: tb/flash_status_timer_tb_top.sv
`timescale 1ns/1ps
module flash_status_timer_tb_top;

  localparam int PROG = 2000;
  localparam int XFER = 200;
  localparam logic [7:0] BYTE_READY = 8'h9C;
  localparam logic [7:0] BYTE_BUSY  = 8'h1C;

  // {class, expected busy cycles}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'(XFER)}, {3'd1, 16'(XFER)}, {3'd2, 16'(PROG)}, {3'd3, 16'(PROG)},
    {3'd4, 16'(PROG)}, {3'd5, 16'(PROG)}, {3'd6, 16'(PROG)}, {3'd7, 16'(PROG)}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launchValid = 1'b0;
  logic [2:0] launchClass = 3'd0;
  logic readActive = 1'b0;
  logic shiftStb = 1'b0;
  logic so, ready;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_status_timer #(.PROG_CYCLES(PROG), .XFER_CYCLES(XFER)) dut_i (
    .clk(clk), .rst_n(rst_n), .launchValid(launchValid), .launchClass(launchClass),
    .readActive(readActive), .shiftStb(shiftStb), .so(so), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Starts at a falling edge; reads 8 bits with back-to-back strobes, then samples the wrap bit
  task automatic read_byte(output logic [7:0] b, output logic wrapBit);
    readActive = 1'b1;
    shiftStb = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #1 b[i] = so;
      @(negedge clk);
    end
    shiftStb = 1'b0;
    #1 wrapBit = so;
    readActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic launch_op(input logic [2:0] cls);
    launchValid = 1'b1;
    launchClass = cls;
    @(negedge clk);
    launchValid = 1'b0;
  endtask

  task automatic wait_ready(output int cycles);
    cycles = 0;
    while (!ready && cycles < 10000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic w;
    int n;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(ready), 1);
    check("R1 so in reset", int'(so), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(ready), 1);
    check("R1 so after reset", int'(so), 0);

    // R2 / R3: idle status byte and wrap
    read_byte(b, w);
    check("R2 idle status byte", int'(b), int'(BYTE_READY));
    check("R3 wrap to bit7", int'(w), 1);

    // R4: vector table, one launch per class
    for (int v = 0; v < 8; v++) begin
      launch_op(VEC[v][18:16]);
      wait_ready(n);
      check($sformatf("R4 busy length class %0d", VEC[v][18:16]), n, int'(VEC[v][15:0]));
      read_byte(b, w);
      check($sformatf("R2 status after class %0d", VEC[v][18:16]), int'(b), int'(BYTE_READY));
    end

    // R2 / R3: status byte read while busy
    launch_op(3'd2);
    read_byte(b, w);
    check("R2 busy status byte", int'(b), int'(BYTE_BUSY));
    check("R3 wrap shows busy bit7", int'(w), 0);
    wait_ready(n);
    check("R4 busy length with read", n + 9, PROG);

    // R5: launch while busy is ignored
    launch_op(3'd4);
    n = 0;
    while (!ready && n < 10000) begin
      n++;
      if (n == 100) begin
        launchValid = 1'b1;
        launchClass = 3'd0;
      end else begin
        launchValid = 1'b0;
      end
      @(negedge clk);
    end
    launchValid = 1'b0;
    check("R5 busy length unchanged", n, PROG);
    @(negedge clk);
    check("R5 ready stays high after", int'(ready), 1);

    // R6: continuous polling of bit 7
    readActive = 1'b1;
    #1 check("R6 poll before launch", int'(so), 1);
    launch_op(3'd1);
    n = 0;
    while (!so && n < 10000) begin
      n++;
      @(negedge clk);
    end
    check("R6 poll low cycles", n, XFER);
    #1 check("R6 poll rises to one", int'(so), 1);
    readActive = 1'b0;
    @(negedge clk);

    // R7: abort mid-read, stray strobes, restart at bit 7
    readActive = 1'b1;
    shiftStb = 1'b1;
    repeat (3) @(negedge clk);
    shiftStb = 1'b0;
    readActive = 1'b0;
    #1 check("R7 so low outside read", int'(so), 0);
    @(negedge clk);
    shiftStb = 1'b1;
    repeat (3) @(negedge clk);
    shiftStb = 1'b0;
    #1 check("R7 so low with stray strobes", int'(so), 0);
    @(negedge clk);
    read_byte(b, w);
    check("R7 restart reads full byte", int'(b), int'(BYTE_READY));

    finish_run();
  end

endmodule